// File: doc/BRIEF.md
# Four-Phase Read Handshake Controller

This block is a clocked model of the controller that runs a read transfer between a bus master and a local device. The master asks for data with a read strobe. The controller passes the request to the device as a local strobe and waits for the device to acknowledge. It then enables the data transceiver and finally acknowledges the master. When the master withdraws its strobe, the controller unwinds the handshake in a fixed order. The transceiver enable drops first. The bus acknowledge and the local strobe are then released in an order chosen by a control pin.

Two protocol points show the same pattern on the five visible handshake lines: one while the local strobe is being raised and one while it is being released. An internal coding bit tells them apart. The bit is set just before the local strobe is raised and cleared once the device has dropped its acknowledge after the strobe release. Both asynchronous inputs pass through synchronizer chains. All outputs come from registers. A sticky error flag reports any input change that breaks the handshake. An optional mode adds one more rule: the device must drop its acknowledge before the master starts the next transfer.

There is no data path through the block, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or status line.

Top module: `rdcyc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `dev_strobe`, `xcvr_en`, `bus_ack`, `proto_err` and the internal coding bit all become 0 and `phase` becomes 0.
- R2: A rise of `bus_strobe` in phase 0 sets the coding bit and moves `phase` to 1 on the third rising edge after the input change. `dev_strobe` rises on the fourth edge, together with `phase` 2. `dev_strobe` never rises while the coding bit is clear.
- R3: `xcvr_en` stays low until `dev_ack` is high. It rises on the third edge after `dev_ack` rises, with `phase` 3. `bus_ack` rises one edge later, with `phase` 4, and only while `xcvr_en` is high.
- R4: A fall of `bus_strobe` in phase 4 drops `xcvr_en` on the third edge after the change, with `phase` 5. `bus_ack` and `dev_strobe` are both still high at that point and neither falls while `xcvr_en` is high.
- R5: The edge after phase 5 releases one line and the next edge releases the other. With `release_bus_first`=1, `bus_ack` falls first (`phase` 6). With `release_bus_first`=0, `dev_strobe` falls first (`phase` 7). Both orders lead to `phase` 8.
- R6: Phase 8 holds while `dev_ack` is high. On the third edge after `dev_ack` falls, the coding bit clears and `phase` returns to 0. With `assume_fast_release`=0, a new `bus_strobe` rise seen while `dev_ack` is still high is accepted without error, and the next transfer starts from phase 0.
- R7: `phase` codes are 0 idle, 1 armed, 2 strobing, 3 enabled, 4 acknowledged, 5 data off, 6 bus released, 7 device released, 8 awaiting device release.
- R8: `proto_err` rises on the third edge after any of these input changes: `bus_strobe` falls while `bus_ack` is low; `dev_ack` rises while `dev_strobe` is low; `dev_ack` falls while `dev_strobe` is high; `bus_strobe` rises while `bus_ack` is high. Once set, `proto_err` stays high until reset.
- R9: With `assume_fast_release`=1, a `bus_strobe` rise seen while `dev_ack` is still high also sets `proto_err`. A transfer in which `dev_ack` falls before the next strobe sets no error.
- R10: `xcvr_en` is never high while `dev_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_strobe | input | 1 | Read strobe from the bus master, asynchronous |
| dev_ack | input | 1 | Acknowledge from the local device, asynchronous |
| release_bus_first | input | 1 | 1: drop bus_ack before dev_strobe; 0: the reverse |
| assume_fast_release | input | 1 | 1: a strobe rise while dev_ack is high is an error |
| dev_strobe | output | 1 | Local strobe to the device |
| xcvr_en | output | 1 | Data transceiver enable |
| bus_ack | output | 1 | Data acknowledge to the bus master |
| phase | output | 4 | Current protocol phase, codes in R7 |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
Each input change takes two edges to cross the synchronizer. The first visible reaction to it therefore lands on the third rising edge: the coding bit and phase 1 after a strobe rise, `xcvr_en` after an acknowledge rise, the data-off phase after a strobe fall, the return to idle after an acknowledge fall, and `proto_err` after a violation. Follow-on steps come one edge apart: the local strobe on the fourth edge, the bus acknowledge one edge after the enable, and the two releases on the two edges after the enable drops. The bench changes inputs just after a falling edge and counts falling edges to the exact cycle where each result is due. It samples there, and it also checks the cycle before, so an output that moves early is caught as well as one that moves late.

// File: rtl/rdcyc_pkg.sv
package rdcyc_pkg;

  localparam int PHASE_W = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE     = 4'd0,
    PH_ARM      = 4'd1,
    PH_STROBE   = 4'd2,
    PH_ENABLE   = 4'd3,
    PH_ACKED    = 4'd4,
    PH_DATA_OFF = 4'd5,
    PH_REL_BUS  = 4'd6,
    PH_REL_DEV  = 4'd7,
    PH_WAIT_DEV = 4'd8
  } phase_e;

endpackage

// File: rtl/rdcyc_sync.sv
module rdcyc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  // a chain of at least two flops per bit
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], d_in};
  end

  assign d_out = chain_q[DEPTH-1];

endmodule

// File: rtl/rdcyc_fsm.sv
module rdcyc_fsm
  import rdcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   ack,
  input  logic   bus_first,
  output phase_e phase,
  output logic   code_bit,
  output logic   dev_strobe,
  output logic   xcvr_en,
  output logic   bus_ack
);

  phase_e phase_q;
  logic   code_q, lds_q, den_q, dtack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      code_q  <= 1'b0;
      lds_q   <= 1'b0;
      den_q   <= 1'b0;
      dtack_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req) begin
          phase_q <= PH_ARM;
          code_q  <= 1'b1;
        end
        PH_ARM: begin
          phase_q <= PH_STROBE;
          lds_q   <= 1'b1;
        end
        PH_STROBE: if (ack) begin
          phase_q <= PH_ENABLE;
          den_q   <= 1'b1;
        end
        PH_ENABLE: begin
          phase_q <= PH_ACKED;
          dtack_q <= 1'b1;
        end
        PH_ACKED: if (!req) begin
          phase_q <= PH_DATA_OFF;
          den_q   <= 1'b0;
        end
        PH_DATA_OFF: begin
          if (bus_first) begin
            phase_q <= PH_REL_BUS;
            dtack_q <= 1'b0;
          end else begin
            phase_q <= PH_REL_DEV;
            lds_q   <= 1'b0;
          end
        end
        PH_REL_BUS: begin
          phase_q <= PH_WAIT_DEV;
          lds_q   <= 1'b0;
        end
        PH_REL_DEV: begin
          phase_q <= PH_WAIT_DEV;
          dtack_q <= 1'b0;
        end
        PH_WAIT_DEV: if (!ack) begin
          phase_q <= PH_IDLE;
          code_q  <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign code_bit   = code_q;
  assign dev_strobe = lds_q;
  assign xcvr_en    = den_q;
  assign bus_ack    = dtack_q;

  // R10
  den_needs_lds_chk: assert property (@(posedge clk) disable iff (rst)
    den_q |-> lds_q);

  // R2
  lds_needs_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lds_q) |-> code_q);

  // R3
  dtack_after_den_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_q) |-> den_q);

  // R4
  dtack_drop_after_den_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_q) |-> !den_q);

  // R4
  lds_drop_after_den_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lds_q) |-> !den_q);

  // R6
  code_clear_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(code_q) |-> (!lds_q && !dtack_q));

endmodule

// File: rtl/rdcyc_guard.sv
module rdcyc_guard (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic dev_strobe,
  input  logic bus_ack,
  input  logic fast_mode,
  output logic err
);

  logic req_q, ack_q, err_q;
  logic req_rise, req_fall, ack_rise, ack_fall, viol;

  assign req_rise = req & ~req_q;
  assign req_fall = ~req & req_q;
  assign ack_rise = ack & ~ack_q;
  assign ack_fall = ~ack & ack_q;

  assign viol = (req_fall & ~bus_ack)
              | (req_rise &  bus_ack)
              | (ack_rise & ~dev_strobe)
              | (ack_fall &  dev_strobe)
              | (fast_mode & req_rise & ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      req_q <= req;
      ack_q <= ack;
      err_q <= err_q | viol;
    end
  end

  assign err = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R1
  err_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !err_q);

endmodule

// File: rtl/rdcyc_ctrl.sv
module rdcyc_ctrl
  import rdcyc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_strobe,
  input  logic               dev_ack,
  input  logic               release_bus_first,
  input  logic               assume_fast_release,
  output logic               dev_strobe,
  output logic               xcvr_en,
  output logic               bus_ack,
  output logic [PHASE_W-1:0] phase,
  output logic               proto_err
);

  logic [1:0] raw_in, sync_w;
  logic       req_s, ack_s, code_bit;
  phase_e     phase_w;

  assign raw_in = {bus_strobe, dev_ack};

  rdcyc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_in),
    .d_out (sync_w)
  );

  assign req_s = sync_w[1];
  assign ack_s = sync_w[0];

  rdcyc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req_s),
    .ack        (ack_s),
    .bus_first  (release_bus_first),
    .phase      (phase_w),
    .code_bit   (code_bit),
    .dev_strobe (dev_strobe),
    .xcvr_en    (xcvr_en),
    .bus_ack    (bus_ack)
  );

  rdcyc_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .req        (req_s),
    .ack        (ack_s),
    .dev_strobe (dev_strobe),
    .bus_ack    (bus_ack),
    .fast_mode  (assume_fast_release),
    .err        (proto_err)
  );

  assign phase = phase_w;

  // R2
  code_set_while_active_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_strobe || bus_ack) |-> code_bit);

endmodule

// File: tb/rdcyc_ctrl_bench.sv
module rdcyc_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_strobe = 1'b0, dev_ack = 1'b0;
  logic       release_bus_first = 1'b0, assume_fast_release = 1'b0;
  logic       dev_strobe, xcvr_en, bus_ack, proto_err;
  logic [3:0] phase;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  strobe_pending = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdcyc_ctrl u_rdcyc_ctrl (
    .clk                 (clk),
    .rst                 (rst),
    .bus_strobe          (bus_strobe),
    .dev_ack             (dev_ack),
    .release_bus_first   (release_bus_first),
    .assume_fast_release (assume_fast_release),
    .dev_strobe          (dev_strobe),
    .xcvr_en             (xcvr_en),
    .bus_ack             (bus_ack),
    .phase               (phase),
    .proto_err           (proto_err)
  );

  // phase codes as the requirement table lists them (R7)
  function automatic int ph(string name);
    case (name)
      "idle":     return 0;
      "arm":      return 1;
      "strobe":   return 2;
      "enable":   return 3;
      "acked":    return 4;
      "data_off": return 5;
      "rel_bus":  return 6;
      "rel_dev":  return 7;
      default:    return 8;
    endcase
  endfunction

  // {bus_ack, dev_strobe} one edge after the data-off phase (R5)
  function automatic int first_release(bit bus_first);
    return bus_first ? 1 : 2;
  endfunction

  function automatic int after_first_phase(bit bus_first);
    return bus_first ? ph("rel_bus") : ph("rel_dev");
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bus_strobe = 1'b0;
    dev_ack = 1'b0;
    strobe_pending = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  // one full read transfer with exact-cycle checks
  task automatic run_cycle(bit bus_first, int dev_dly, int hold_dly, bit early_next);
    release_bus_first = bus_first;
    if (strobe_pending) begin
      // strobe already high, controller just returned to idle
      tick(1);
      chk(phase == 4'(ph("arm")), "R6", phase, ph("arm"));
      tick(1);
      chk(dev_strobe == 1'b1, "R6", dev_strobe, 1);
    end else begin
      bus_strobe = 1'b1;
      tick(2);
      chk(phase == 4'(ph("idle")), "R2", phase, ph("idle"));
      tick(1);
      chk(phase == 4'(ph("arm")) && !dev_strobe, "R2", phase, ph("arm"));
      tick(1);
      chk(dev_strobe == 1'b1 && phase == 4'(ph("strobe")), "R2", dev_strobe, 1);
    end
    strobe_pending = 1'b0;
    tick(dev_dly);
    chk(!xcvr_en && !bus_ack, "R3", xcvr_en, 0);
    dev_ack = 1'b1;
    tick(2);
    chk(!xcvr_en, "R3", xcvr_en, 0);
    tick(1);
    chk(xcvr_en && !bus_ack && phase == 4'(ph("enable")), "R3", {xcvr_en, bus_ack}, 2);
    tick(1);
    chk(bus_ack && phase == 4'(ph("acked")), "R3", bus_ack, 1);
    tick(hold_dly);
    bus_strobe = 1'b0;
    tick(2);
    chk(xcvr_en == 1'b1, "R4", xcvr_en, 1);
    tick(1);
    chk(!xcvr_en && bus_ack && dev_strobe, "R4", {xcvr_en, bus_ack, dev_strobe}, 3);
    tick(1);
    chk(int'({bus_ack, dev_strobe}) == first_release(bus_first), "R5",
        {bus_ack, dev_strobe}, first_release(bus_first));
    chk(phase == 4'(after_first_phase(bus_first)), "R5", phase, after_first_phase(bus_first));
    tick(1);
    chk(!bus_ack && !dev_strobe && phase == 4'(ph("wait")), "R5", phase, ph("wait"));
    if (early_next) begin
      bus_strobe = 1'b1;
      strobe_pending = 1'b1;
    end
    tick(dev_dly);
    chk(phase == 4'(ph("wait")), "R6", phase, ph("wait"));
    dev_ack = 1'b0;
    tick(2);
    chk(phase == 4'(ph("wait")), "R6", phase, ph("wait"));
    tick(1);
    chk(phase == 4'(ph("idle")), "R6", phase, ph("idle"));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c7));
    do_reset();
    // R1
    chk(!dev_strobe && !xcvr_en && !bus_ack && !proto_err, "R1",
        {dev_strobe, xcvr_en, bus_ack, proto_err}, 0);
    chk(phase == 4'(ph("idle")), "R1 R7", phase, 0);

    // directed: both release orders, the strobe held high across the return to idle
    run_cycle(1'b1, 0, 0, 1'b0);
    run_cycle(1'b0, 2, 1, 1'b0);
    run_cycle(1'b1, 1, 0, 1'b1);
    run_cycle(1'b0, 3, 2, 1'b1);
    run_cycle(1'b1, 0, 0, 1'b0);
    chk(!proto_err, "R6", proto_err, 0);

    // random transfers in relaxed mode
    for (int i = 0; i < 40; i++) begin
      run_cycle(1'($urandom % 2), int'($urandom % 4), int'($urandom % 4), ($urandom % 3) == 0);
    end
    run_cycle(1'b0, 1, 1, 1'b0);
    chk(!proto_err, "R8 no false error", proto_err, 0);

    // R8: acknowledge rises while strobe is low
    do_reset();
    dev_ack = 1'b1;
    tick(2);
    chk(!proto_err, "R8", proto_err, 0);
    tick(1);
    chk(proto_err, "R8", proto_err, 1);
    dev_ack = 1'b0;
    tick(6);
    chk(proto_err, "R8 sticky", proto_err, 1);
    do_reset();
    chk(!proto_err, "R1", proto_err, 0);

    // R8: strobe withdrawn before the bus acknowledge
    bus_strobe = 1'b1;
    tick(4);
    bus_strobe = 1'b0;
    tick(2);
    chk(!proto_err, "R8", proto_err, 0);
    tick(1);
    chk(proto_err, "R8", proto_err, 1);

    // R8: acknowledge drops while the local strobe is high
    do_reset();
    bus_strobe = 1'b1;
    tick(4);
    dev_ack = 1'b1;
    tick(4);
    dev_ack = 1'b0;
    tick(3);
    chk(proto_err, "R8", proto_err, 1);

    // R8: strobe rises again while the bus acknowledge is high
    do_reset();
    bus_strobe = 1'b1;
    tick(4);
    dev_ack = 1'b1;
    tick(4);
    chk(bus_ack, "R3", bus_ack, 1);
    bus_strobe = 1'b0;
    tick(1);
    bus_strobe = 1'b1;
    tick(2);
    chk(!proto_err, "R8", proto_err, 0);
    tick(1);
    chk(proto_err, "R8", proto_err, 1);

    // R9: fast-release mode, clean transfer then early strobe
    do_reset();
    assume_fast_release = 1'b1;
    run_cycle(1'b1, 1, 1, 1'b0);
    chk(!proto_err, "R9", proto_err, 0);
    run_cycle(1'b0, 0, 0, 1'b0);
    chk(!proto_err, "R9", proto_err, 0);
    run_cycle(1'b1, 4, 0, 1'b1);
    chk(proto_err, "R9", proto_err, 1);
    assume_fast_release = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule